// File: doc/BRIEF.md
# Program/Erase Busy Status Polling Unit

This block lives on the read path of a flash array controller. It stands in for the internal timer of a long-running array operation and decides what a read returns while that operation runs. An accepted start pulse carries the kind of operation (byte program or full erase) and the byte the host loaded last. The block then stays busy for a fixed number of clock cycles, chosen by parameter for each kind.

While busy, a read does not return array contents. It returns a status byte that carries two completion hints at once. The top bit is a data-polling bit: during a program it is the inverse of the top bit of the loaded byte, and during an erase it is 0. The bit below it flips on every read. When the count runs out, the block pulses a completion strobe and presents the value the target byte should hold. Reads from then on pass the array data through unchanged.

Top module: `pesp_poll_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `rd_valid_o` and `done_o` are all 0.
- R2: `start_i` high at an edge while idle is accepted. `busy_o` is then 1 for exactly PROG_CYCLES clock cycles when `op_erase_i` was 0 (program), or ERASE_CYCLES cycles when it was 1 (erase), starting in the cycle after the accepting edge.
- R3: During a program, every read returns the inverse of bit 7 of the loaded byte on `rd_data_o[7]`.
- R4: During an erase, every read returns 0 on `rd_data_o[7]`.
- R5: During any operation, `rd_data_o[6]` alternates on each read. The first read after a start returns 1, the next 0, and so on, even when idle cycles lie between reads. Bits 5 to 0 of a busy read are 0.
- R6: A read while idle returns `array_data_i` as sampled at the read edge. Each read (`rd_i` high at an edge) gives `rd_valid_o` high with its data in the following cycle.
- R7: A `start_i` pulse while busy is ignored. The running operation keeps its kind, its loaded byte and its remaining length.
- R8: When an operation ends, `done_o` is high for one cycle, in the first cycle with `busy_o` low. For a program, `commit_data_o` then holds the old byte (`array_data_i` at the start edge) ANDed with the loaded byte. For an erase it holds all ones.
- R9: A read at the last busy edge still returns status. The very next read returns true array data, and bit 6 stops alternating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request for a new operation |
| op_erase_i | input | 1 | Operation kind with start: 0 program, 1 erase |
| load_data_i | input | DATA_W | Last loaded byte, sampled with start |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | DATA_W | Array byte at the read or target address |
| rd_data_o | output | DATA_W | Read result, status or array data |
| rd_valid_o | output | 1 | Read result valid, one cycle after `rd_i` |
| busy_o | output | 1 | Internal operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| commit_data_o | output | DATA_W | Final byte value, meaningful with `done_o` |

## Verification
The bench reads on every cycle of a program, including the last busy edge and the edge just after it. A timer that is off by one would leak array data early, or return a status byte after completion. A second program leaves idle gaps between reads and reads right after the start. A toggle that was not cleared at start, or that flipped on every clock instead of on every read, would then show the wrong bit 6. Start pulses during a program, during an erase, and exactly on the final busy edge catch a design that reloads its counter or takes on the new kind or byte. The erase pass and a loaded byte with bit 7 set catch a polling bit that ignores the operation kind or the loaded value.

// File: rtl/pesp_pkg.sv
// Shared types for the program/erase status polling unit.
package pesp_pkg;
    // Kind of internal operation the unit is timing.
    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;
endpackage

// File: rtl/pesp_busy_timer.sv
// Busy timer: stands in for the internal operation timer.
// Accepts a start only while idle, loads a per-kind cycle count, keeps busy
// high for exactly that many cycles and emits a one-cycle done strobe.
// Assumes PROG_CYCLES and ERASE_CYCLES are at least 1 and fit in CNT_W bits.
module pesp_busy_timer
    import pesp_pkg::*;
#(
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40,
    parameter int CNT_W        = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  op_kind_e op_i,
    output logic     accept_o,
    output logic     busy_o,
    output logic     done_o
);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    // A start counts only when no operation is running.
    assign accept_o = start_i && !busy_q;

    // Count down the remaining busy cycles and flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= (op_i == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    // R7
    no_reload_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

    // R2
    busy_end_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);
endmodule

// File: rtl/pesp_commit_latch.sv
// Operation context latch: on an accepted start it keeps the operation kind,
// the top bit of the loaded byte and the merged program result. Programming
// can only clear bits, so the result is old AND new; an erase yields all ones.
// Assumes old_i carries the target byte's current value at the start edge.
module pesp_commit_latch
    import pesp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  op_kind_e          op_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic [DATA_W-1:0] old_i,
    output op_kind_e          op_q_o,
    output logic              load_msb_o,
    output logic [DATA_W-1:0] commit_data_o
);
    op_kind_e          op_q;
    logic              msb_q;
    logic [DATA_W-1:0] merged_q;

    // Capture the context of an accepted operation; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_PROGRAM;
            msb_q    <= 1'b0;
            merged_q <= '1;
        end else if (accept_i) begin
            op_q     <= op_i;
            msb_q    <= load_i[DATA_W-1];
            merged_q <= old_i & load_i;
        end
    end

    assign op_q_o        = op_q;
    assign load_msb_o    = msb_q;
    assign commit_data_o = (op_q == OP_ERASE) ? '1 : merged_q;

    // R7
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> (op_q == $past(op_q) && msb_q == $past(msb_q)));
endmodule

// File: rtl/pesp_read_status.sv
// Read formatter: registers one result per read strobe. While busy it builds
// the status byte (polling bit on top, toggle bit below it, zeros beneath);
// while idle it forwards array data. Toggle is cleared on every accepted
// start and flips once per busy read. Assumes DATA_W is at least 3.
module pesp_read_status
    import pesp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              busy_i,
    input  logic              accept_i,
    input  op_kind_e          op_i,
    input  logic              load_msb_i,
    input  logic [DATA_W-1:0] array_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TGL_BIT  = DATA_W - 2;

    logic              toggle_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              poll_bit;
    logic [DATA_W-1:0] status_byte;

    // Polling bit: inverted loaded MSB during program, 0 during erase.
    assign poll_bit = (op_i == OP_ERASE) ? 1'b0 : !load_msb_i;

    // Assemble the busy status byte from the polling and next toggle values.
    always_comb begin
        status_byte           = '0;
        status_byte[POLL_BIT] = poll_bit;
        status_byte[TGL_BIT]  = !toggle_q;
    end

    // Toggle state: cleared at start, advanced by each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else if (accept_i) begin
            toggle_q <= 1'b0;
        end else if (rd_i && busy_i) begin
            toggle_q <= !toggle_q;
        end
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= rd_i;
            if (rd_i) begin
                data_q <= busy_i ? status_byte : array_i;
            end
        end
    end

    assign rd_valid_o = valid_q;
    assign rd_data_o  = data_q;

    // R3
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i && op_i == OP_PROGRAM) |=> (rd_data_o[POLL_BIT] == !$past(load_msb_i)));

    // R4
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i && op_i == OP_ERASE) |=> (rd_data_o[POLL_BIT] == 1'b0));

    // R5
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i) |=> (rd_data_o[TGL_BIT-1:0] == '0));

    // R6
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !busy_i) |=> (rd_valid_o && rd_data_o == $past(array_i)));
endmodule

// File: rtl/pesp_poll_unit.sv
// Program/erase status polling unit, top level.
// Ties the busy timer, the operation context latch and the read formatter.
// Assumes the caller presents the target byte on array_data_i with start_i
// and the addressed byte with rd_i; command decoding and cell driving are
// handled elsewhere.
module pesp_poll_unit
    import pesp_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] commit_data_o
);
    localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

    op_kind_e op_in;
    op_kind_e op_run;
    logic     accept;
    logic     busy;
    logic     done;
    logic     load_msb;

    assign op_in = op_erase_i ? OP_ERASE : OP_PROGRAM;

    pesp_busy_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES),
        .CNT_W       (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_in),
        .accept_o(accept),
        .busy_o  (busy),
        .done_o  (done)
    );

    pesp_commit_latch #(
        .DATA_W(DATA_W)
    ) i_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .op_i         (op_in),
        .load_i       (load_data_i),
        .old_i        (array_data_i),
        .op_q_o       (op_run),
        .load_msb_o   (load_msb),
        .commit_data_o(commit_data_o)
    );

    pesp_read_status #(
        .DATA_W(DATA_W)
    ) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_i),
        .busy_i    (busy),
        .accept_i  (accept),
        .op_i      (op_run),
        .load_msb_i(load_msb),
        .array_i   (array_data_i),
        .rd_valid_o(rd_valid_o),
        .rd_data_o (rd_data_o)
    );

    assign busy_o = busy;
    assign done_o = done;

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/test_pesp_poll_unit.sv
// Scoreboard bench: the driver task predicts each read result and pushes it
// into a queue; a monitor pops and compares whenever rd_valid_o is high.
module test_pesp_poll_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_N     = 12;
    localparam int ERASE_N    = 40;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } rd_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_erase_i = 1'b0;
    logic [7:0] load_data_i = '0;
    logic       rd_i = 1'b0;
    logic [7:0] array_data_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_valid_o;
    logic       busy_o;
    logic       done_o;
    logic [7:0] commit_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    rd_item_t   sb_q[$];
    int         m_left = 0;
    bit         m_erase = 1'b0;
    bit         m_msb = 1'b0;
    bit         m_tgl = 1'b0;
    bit         m_done = 1'b0;
    logic [7:0] m_commit = 8'hFF;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pesp_poll_unit #(
        .DATA_W      (8),
        .PROG_CYCLES (PROG_N),
        .ERASE_CYCLES(ERASE_N)
    ) i_pesp_poll_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_erase_i   (op_erase_i),
        .load_data_i  (load_data_i),
        .rd_i         (rd_i),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o),
        .rd_valid_o   (rd_valid_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .commit_data_o(commit_data_o)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare every read result against the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R6 unexpected read", rd_data_o, 8'h00);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk(rd_data_o === it.exp, it.req, rd_data_o, it.exp);
            end
        end
    end

    // Driver: one clock with the given inputs, updating the model.
    task automatic step(input bit st, input bit er, input logic [7:0] ld,
                        input bit rd, input logic [7:0] arr);
        rd_item_t it;
        start_i      = st;
        op_erase_i   = er;
        load_data_i  = ld;
        rd_i         = rd;
        array_data_i = arr;
        if (rd) begin
            if (m_left > 0) begin
                m_tgl  = ~m_tgl;
                it.exp = {(m_erase ? 1'b0 : ~m_msb), m_tgl, 6'b0};
                it.req = m_erase ? "R4/R5 busy erase read" : "R3/R5/R9 busy program read";
            end else begin
                it.exp = arr;
                it.req = "R6/R9 idle read";
            end
            sb_q.push_back(it);
        end
        @(posedge clk);
        m_done = 1'b0;
        if (st && m_left == 0) begin
            m_left   = er ? ERASE_N : PROG_N;
            m_erase  = er;
            m_msb    = ld[7];
            m_tgl    = 1'b0;
            m_commit = er ? 8'hFF : (arr & ld);
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) m_done = 1'b1;
        end
        @(negedge clk);
        chk(busy_o === (m_left > 0), "R2/R7 busy", {7'b0, busy_o}, {7'b0, m_left > 0});
        chk(done_o === m_done, "R8 done", {7'b0, done_o}, {7'b0, m_done});
        if (m_done) chk(commit_data_o === m_commit, "R8 commit", commit_data_o, m_commit);
        start_i = 1'b0;
        rd_i    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(busy_o === 1'b0, "R1 busy", {7'b0, busy_o}, 8'h00);
        chk(rd_valid_o === 1'b0, "R1 valid", {7'b0, rd_valid_o}, 8'h00);
        chk(done_o === 1'b0, "R1 done", {7'b0, done_o}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R6 idle reads with several patterns
        step(1'b0, 1'b0, 8'h00, 1'b1, 8'hA5);
        step(1'b0, 1'b0, 8'h00, 1'b1, 8'h3C);
        step(1'b0, 1'b0, 8'h00, 1'b1, 8'h00);
        idle(2);

        // Program, loaded bit7 = 0, read every cycle through the end (R3, R5, R9)
        step(1'b1, 1'b0, 8'h5A, 1'b0, 8'hF0);
        for (int i = 0; i < PROG_N + 3; i++) begin
            // R7: start attempts mid-run and on the final busy edge
            bit st;
            st = (i == 4) || (i == PROG_N - 1);
            step(st, 1'b1, 8'h00, 1'b1, 8'h96 + 8'(i));
        end
        idle(2);

        // Program, loaded bit7 = 1, sparse reads with gaps (R3, R5)
        step(1'b1, 1'b0, 8'h81, 1'b0, 8'hFF);
        for (int i = 0; i < PROG_N + 2; i++) begin
            step(1'b0, 1'b0, 8'h00, (i % 3) != 1, 8'h42);
        end
        idle(2);

        // Erase, reads with gaps and a stray start (R4, R7, R8)
        step(1'b1, 1'b1, 8'h7E, 1'b0, 8'h12);
        for (int i = 0; i < ERASE_N + 2; i++) begin
            step(i == 10, 1'b0, 8'h00, (i % 2) == 0, 8'hC3);
        end
        idle(2);

        // Read on the same edge as a start still sees idle data (R6)
        step(1'b1, 1'b0, 8'h0F, 1'b1, 8'hE7);
        idle(PROG_N + 2);

        chk(sb_q.size() == 0, "R6 pending reads", 8'(sb_q.size()), 8'h00);
        finish_run();
    end
endmodule